// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a general-purpose I/O port of up to 32 pins behind a small word-addressed register bus. For every pin that is built in, software holds a direction bit, an output value, a pull-up request and two alternate-function select bits. These values drive the pad control outputs directly. The pad input is brought through a two-flop synchronizer. Software reads the synchronized value, and the interrupt detectors watch it.

Each pin's trigger is set by three bits, and each of the three bits lives in its own per-pin register. The first edge bit selects rising or high. The second edge bit selects falling or low. The level bit switches the pin from edge detection to level detection. Edge events set a sticky pending flag, which software clears by writing ones to the status word. A level-mode pending flag follows the qualifying pin level, but only while that pin is enabled. The interrupt enable mask is never written directly: one word sets mask bits and another clears them, so pins owned by different software threads can be changed without a read-modify-write. The single interrupt line is the OR of all pending flags masked by the enables.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads 0, all pad control outputs are 0, no pin is pending and `irq` is 0.
- R2: The registers at 0x04 (output value), 0x08 (direction, 1 = output), 0x0C (pull-up), 0x10 (alt select 0) and 0x14 (alt select 1) are plain read/write bit vectors, with bit n belonging to pin n. Each drives its pad output in the cycle after the write.
- R3: Offset 0x00 returns the pad inputs after two register stages. A change driven before clock edge k is readable after edge k+1 and not after edge k.
- R4: Writing to 0x24 sets each enable bit whose data bit is 1 and leaves the others alone. The enable mask reads back at 0x2C. Offsets 0x24 and 0x28 read as 0.
- R5: Writing to 0x28 clears each enable bit whose data bit is 1 and leaves the others alone.
- R6: A pin's mode is {level bit at 0x20, edge-1 bit at 0x1C, edge-0 bit at 0x18}. Mode 0 never triggers, mode 1 triggers on a rising edge, mode 2 on a falling edge and mode 3 on either edge.
- R7: An edge-mode pending bit (status at 0x30) stays set until software writes 1 to its bit at 0x30. If a new edge and a clear arrive in the same cycle, the bit stays set.
- R8: Mode 5 holds pending while the synchronized pin is high, and mode 6 while it is low. In any level mode a disabled pin is never pending.
- R9: `irq` is 1 exactly when some pin is both pending and enabled. `irq_pending` mirrors the status word.
- R10: Bits of pins at or above NUM_PINS read 0 in every register, and writes to those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| pad_out | output | NUM_PINS | Output value to pads |
| pad_oe | output | NUM_PINS | Pad output enable (direction) |
| pad_pull_en | output | NUM_PINS | Pull-up request |
| pad_alt0 | output | NUM_PINS | Alternate-function select bit 0 |
| pad_alt1 | output | NUM_PINS | Alternate-function select bit 1 |
| irq_pending | output | NUM_PINS | Per-pin pending flags |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a clear write to the status word that lands in the same clock as a fresh edge. Reaching it requires counting the synchronizer and edge-register stages exactly. The bench drives the pin between edges, waits two rising edges, and issues the clear so that its write edge is the third one. It then confirms that the flag survived. Random rounds cover the other ground. Each round sets a random mode and enable per pin and settles an old pad pattern. It then clears the status and applies a new pattern. Finally it compares the status against a per-pin model of edges and levels.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 6;

    typedef enum logic [3:0] {
        RI_IN     = 4'd0,
        RI_OUT    = 4'd1,
        RI_DIR    = 4'd2,
        RI_PULL   = 4'd3,
        RI_ALT0   = 4'd4,
        RI_ALT1   = 4'd5,
        RI_EDGE0  = 4'd6,
        RI_EDGE1  = 4'd7,
        RI_LEVEL  = 4'd8,
        RI_EN_SET = 4'd9,
        RI_EN_CLR = 4'd10,
        RI_EN     = 4'd11,
        RI_PEND   = 4'd12
    } reg_idx_e;

    typedef struct packed {
        logic lvl;
        logic e1;
        logic e0;
    } trig_cfg_t;

    function automatic logic edge_fire(trig_cfg_t tc, logic cur, logic prev);
        return !tc.lvl && ((tc.e0 && cur && !prev) || (tc.e1 && !cur && prev));
    endfunction

    function automatic logic level_fire(trig_cfg_t tc, logic cur);
        return tc.lvl && ((tc.e0 && cur) || (tc.e1 && !cur));
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W      = 20,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         chain_q[s] <= '0;
                else if (s == 0) chain_q[s] <= d;
                else             chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_sync,
    input  logic [NUM_PINS-1:0] pend,
    output logic [NUM_PINS-1:0] out_q,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] pull_q,
    output logic [NUM_PINS-1:0] alt0_q,
    output logic [NUM_PINS-1:0] alt1_q,
    output logic [NUM_PINS-1:0] edge0_q,
    output logic [NUM_PINS-1:0] edge1_q,
    output logic [NUM_PINS-1:0] level_q,
    output logic [NUM_PINS-1:0] en_q,
    output logic [NUM_PINS-1:0] pend_clr
);
    logic                aligned;
    logic                wr_hit;
    reg_idx_e            idx;
    logic [NUM_PINS-1:0] wd;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_hit  = bus_sel && bus_wr && aligned;
    assign idx     = reg_idx_e'(bus_addr[ADDR_W-1:2]);
    assign wd      = bus_wdata[NUM_PINS-1:0];

    generate
        if (NUM_PINS < BUS_W) begin : g_spare
            logic wdata_unused;
            assign wdata_unused = ^bus_wdata[BUS_W-1:NUM_PINS];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            dir_q   <= '0;
            pull_q  <= '0;
            alt0_q  <= '0;
            alt1_q  <= '0;
            edge0_q <= '0;
            edge1_q <= '0;
            level_q <= '0;
            en_q    <= '0;
        end else if (wr_hit) begin
            case (idx)
                RI_OUT:    out_q   <= wd;
                RI_DIR:    dir_q   <= wd;
                RI_PULL:   pull_q  <= wd;
                RI_ALT0:   alt0_q  <= wd;
                RI_ALT1:   alt1_q  <= wd;
                RI_EDGE0:  edge0_q <= wd;
                RI_EDGE1:  edge1_q <= wd;
                RI_LEVEL:  level_q <= wd;
                RI_EN_SET: en_q    <= en_q | wd;
                RI_EN_CLR: en_q    <= en_q & ~wd;
                default:   ;
            endcase
        end
    end

    assign pend_clr = (wr_hit && idx == RI_PEND) ? wd : '0;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && aligned) begin
            case (idx)
                RI_IN:    bus_rdata[NUM_PINS-1:0] = pin_sync;
                RI_OUT:   bus_rdata[NUM_PINS-1:0] = out_q;
                RI_DIR:   bus_rdata[NUM_PINS-1:0] = dir_q;
                RI_PULL:  bus_rdata[NUM_PINS-1:0] = pull_q;
                RI_ALT0:  bus_rdata[NUM_PINS-1:0] = alt0_q;
                RI_ALT1:  bus_rdata[NUM_PINS-1:0] = alt1_q;
                RI_EDGE0: bus_rdata[NUM_PINS-1:0] = edge0_q;
                RI_EDGE1: bus_rdata[NUM_PINS-1:0] = edge1_q;
                RI_LEVEL: bus_rdata[NUM_PINS-1:0] = level_q;
                RI_EN:    bus_rdata[NUM_PINS-1:0] = en_q;
                RI_PEND:  bus_rdata[NUM_PINS-1:0] = pend;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R4: every 1 in a set-word write is present in the mask afterwards
    p_en_set_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && idx == RI_EN_SET) |=> ((en_q & $past(wd)) == $past(wd)));

    // R5: every 1 in a clear-word write is absent from the mask afterwards
    p_en_clr_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && idx == RI_EN_CLR) |=> ((en_q & $past(wd)) == '0));

    // R4/R5: the mask only moves on writes to the set or clear word
    p_en_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(wr_hit && (idx == RI_EN_SET || idx == RI_EN_CLR)) |=> $stable(en_q));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_sync,
    input  logic [NUM_PINS-1:0] edge0,
    input  logic [NUM_PINS-1:0] edge1,
    input  logic [NUM_PINS-1:0] level,
    input  logic [NUM_PINS-1:0] en,
    input  logic [NUM_PINS-1:0] clr,
    output logic [NUM_PINS-1:0] pend
);
    logic [NUM_PINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pin_sync;
    end

    genvar i;
    generate
        for (i = 0; i < NUM_PINS; i++) begin : g_pin
            trig_cfg_t tc;
            logic      ev_edge;
            logic      ev_level;

            assign tc       = '{lvl: level[i], e1: edge1[i], e0: edge0[i]};
            assign ev_edge  = edge_fire(tc, pin_sync[i], prev_q[i]);
            assign ev_level = level_fire(tc, pin_sync[i]);

            always_ff @(posedge clk) begin
                if (rst)          pend[i] <= 1'b0;
                else if (tc.lvl)  pend[i] <= en[i] && ev_level;
                else if (ev_edge) pend[i] <= 1'b1;
                else if (clr[i])  pend[i] <= 1'b0;
            end

            // R8: a disabled level-mode pin never becomes pending
            p_level_gated_r8: assert property (@(posedge clk) disable iff (rst)
                (level[i] && !en[i]) |=> !pend[i]);

            // R7: an edge-mode flag survives any cycle without a clear write
            p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
                (!level[i] && pend[i] && !clr[i]) |=> pend[i]);

            // R6: mode 0 never raises a fresh flag
            p_mode0_quiet_r6: assert property (@(posedge clk) disable iff (rst)
                (!level[i] && !edge0[i] && !edge1[i] && !pend[i]) |=> !pend[i]);
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [5:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pull_en,
    output logic [NUM_PINS-1:0] pad_alt0,
    output logic [NUM_PINS-1:0] pad_alt1,
    output logic [NUM_PINS-1:0] irq_pending,
    output logic                irq
);
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] edge0, edge1, level, en, pend_clr, pend;

    gpio_irq_sync #(.W(NUM_PINS), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_sync)
    );

    gpio_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_sync  (pin_sync),
        .pend      (pend),
        .out_q     (pad_out),
        .dir_q     (pad_oe),
        .pull_q    (pad_pull_en),
        .alt0_q    (pad_alt0),
        .alt1_q    (pad_alt1),
        .edge0_q   (edge0),
        .edge1_q   (edge1),
        .level_q   (level),
        .en_q      (en),
        .pend_clr  (pend_clr)
    );

    gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .pin_sync (pin_sync),
        .edge0    (edge0),
        .edge1    (edge1),
        .level    (level),
        .en       (en),
        .clr      (pend_clr),
        .pend     (pend)
    );

    assign irq_pending = pend;
    assign irq         = |(pend & en);

    // R9: no interrupt while the enable mask is empty
    p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq);

    // R1: the cycle after reset is quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!irq && pend == '0 && en == '0));
endmodule

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
    localparam int NP = 20;
    localparam logic [31:0] MASK = (32'd1 << NP) - 1;
    localparam logic [5:0] A_IN = 6'h00, A_OUT = 6'h04, A_DIR = 6'h08, A_PULL = 6'h0C,
        A_ALT0 = 6'h10, A_ALT1 = 6'h14, A_E0 = 6'h18, A_E1 = 6'h1C, A_LVL = 6'h20,
        A_ESET = 6'h24, A_ECLR = 6'h28, A_EN = 6'h2C, A_PEND = 6'h30;

    logic clk = 0, rst = 1;
    logic bus_sel = 0, bus_wr = 0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, pad_pull_en, pad_alt0, pad_alt1, irq_pending;
    logic irq;

    int n_cmp = 0, n_bad = 0;

    always #5 clk = ~clk;

    gpio_irq_port #(.NUM_PINS(NP)) u_gpio_irq_port (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pull_en(pad_pull_en), .pad_alt0(pad_alt0), .pad_alt1(pad_alt1),
        .irq_pending(irq_pending), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    // model of the status word after a settled change old -> new
    function automatic logic [31:0] model_pend(logic [31:0] e0, logic [31:0] e1,
        logic [31:0] lv, logic [31:0] en, logic [31:0] o, logic [31:0] n);
        logic [31:0] rise, fall, edge_p, lvl_p;
        rise   = ~o & n;
        fall   = o & ~n;
        edge_p = ~lv & ((e0 & rise) | (e1 & fall));
        lvl_p  = lv & en & ((e0 & n) | (e1 & ~n));
        return (edge_p | lvl_p) & MASK;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r, v, exp_en;
        logic [2:0] modes [6];
        void'($urandom(32'h5EED_1234));
        modes[0] = 3'd0; modes[1] = 3'd1; modes[2] = 3'd2;
        modes[3] = 3'd3; modes[4] = 3'd5; modes[5] = 3'd6;

        idle(4);
        @(negedge clk) rst = 0;

        // R1: reset state
        for (int a = 0; a <= 12; a++) begin
            rd(6'(a * 4), r);
            check("R1 reg", r, 32'h0);
        end
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 oe", 32'(pad_oe), 32'h0);

        // R2 / R10: plain registers and unimplemented bits
        for (int k = 0; k < 4; k++) begin
            v = $urandom();
            wr(A_OUT, v);  rd(A_OUT, r);  check("R2 out", r, v & MASK);
            check("R2 pad_out", 32'(pad_out), v & MASK);
            wr(A_DIR, ~v); rd(A_DIR, r);  check("R2 dir", r, ~v & MASK);
            check("R2 pad_oe", 32'(pad_oe), ~v & MASK);
            wr(A_PULL, v ^ 32'h5A5A5A5A); check("R2 pull", 32'(pad_pull_en), (v ^ 32'h5A5A5A5A) & MASK);
            wr(A_ALT0, v >> 3); rd(A_ALT0, r); check("R2 alt0", r, (v >> 3) & MASK);
            wr(A_ALT1, v << 2); check("R2 alt1", 32'(pad_alt1), (v << 2) & MASK);
        end
        wr(A_DIR, 32'hFFFF_FFFF); rd(A_DIR, r);
        check("R10 upper bits", r, MASK);
        rd(A_ESET, r); check("R4 set word reads 0", r, 32'h0);

        // R3: two-stage input latency
        @(negedge clk) pad_in = NP'(32'h000A_5C3F);
        @(posedge clk);
        rd(A_IN, r); check("R3 not yet", r, 32'h0);
        rd(A_IN, r); check("R3 visible", r, 32'h000A_5C3F & MASK);

        // R4 / R5: set/clear mask
        wr(A_ECLR, 32'hFFFF_FFFF);
        exp_en = 0;
        for (int k = 0; k < 6; k++) begin
            v = $urandom();
            if (k % 2 == 0) begin wr(A_ESET, v); exp_en = (exp_en | v) & MASK; end
            else            begin wr(A_ECLR, v); exp_en = exp_en & ~v; end
            rd(A_EN, r);
            check((k % 2 == 0) ? "R4 enable set" : "R5 enable clear", r, exp_en);
        end
        rd(A_ECLR, r); check("R5 clear word reads 0", r, 32'h0);

        // R6 / R8 / R9: random rounds against the model
        for (int it = 0; it < 40; it++) begin
            logic [31:0] e0, e1, lv, en, o, n, ep;
            e0 = 0; e1 = 0; lv = 0;
            for (int p = 0; p < NP; p++) begin
                logic [2:0] m;
                m = modes[$urandom_range(0, 5)];
                e0[p] = m[0]; e1[p] = m[1]; lv[p] = m[2];
            end
            en = $urandom() & MASK;
            o  = $urandom() & MASK;
            n  = (it % 4 == 0) ? ~o & MASK : $urandom() & MASK;
            wr(A_E0, e0); wr(A_E1, e1); wr(A_LVL, lv);
            wr(A_ECLR, 32'hFFFF_FFFF); wr(A_ESET, en);
            @(negedge clk) pad_in = o[NP-1:0];
            idle(4);
            wr(A_PEND, 32'hFFFF_FFFF);
            @(negedge clk) pad_in = n[NP-1:0];
            idle(4);
            ep = model_pend(e0, e1, lv, en, o, n);
            rd(A_PEND, r);
            check("R6/R8 pending", r, ep);
            check("R9 irq_pending", 32'(irq_pending), ep);
            check("R9 irq", {31'b0, irq}, {31'b0, |(ep & en)});
        end

        // R7: clear and new edge in the same cycle -> stays set
        wr(A_E0, 32'h1); wr(A_E1, 32'h0); wr(A_LVL, 32'h0);
        wr(A_ECLR, 32'hFFFF_FFFF); wr(A_ESET, 32'h1);
        @(negedge clk) pad_in = '0;
        idle(4);
        wr(A_PEND, 32'hFFFF_FFFF);
        rd(A_PEND, r); check("R7 cleared", r, 32'h0);
        @(negedge clk) pad_in = NP'(1);
        idle(2);
        wr(A_PEND, 32'h1);
        rd(A_PEND, r); check("R7 set wins", r, 32'h1);
        idle(3);
        rd(A_PEND, r); check("R7 sticky", r, 32'h1);
        check("R9 irq high", {31'b0, irq}, 32'h1);
        wr(A_PEND, 32'h1);
        rd(A_PEND, r); check("R7 cleared after", r, 32'h0);

        // R8: level high gated by enable, then pin low
        wr(A_E0, 32'h2); wr(A_LVL, 32'h2); wr(A_ECLR, 32'h3);
        @(negedge clk) pad_in = NP'(2);
        idle(4);
        rd(A_PEND, r); check("R8 disabled level", r, 32'h0);
        wr(A_ESET, 32'h2); idle(1);
        rd(A_PEND, r); check("R8 enabled level", r, 32'h2);
        @(negedge clk) pad_in = '0;
        idle(4);
        rd(A_PEND, r); check("R8 follows level", r, 32'h0);
        check("R9 irq low", {31'b0, irq}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule